// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one USB packet at low speed onto the D+ and D- lines, with eight clocks per bit time (a 12 MHz clock gives the 1.5 Mbit/s rate). A caller starts a data packet by giving a byte count. The block then sends the sync byte. After that it pulls the given number of bytes from a byte source, one handshake per byte, and sends each byte least significant bit first. Every bit goes through NRZI encoding and bit stuffing.

A second request input sends a two-byte handshake packet: the sync byte followed by one PID byte that the caller supplies. This packet uses the same encode and stuffing path and does not touch the byte source.

Each packet has the same framing. The lines are first set to idle J, and only then does the block take the bus through its output-enable. The packet ends with two bit times of SE0 and one bit time of J. The block then releases the bus with both lines low. A device-address update that the caller has posted takes effect when a data packet finishes. It does not take effect after a handshake packet or an aborted packet.

Top module: `lsusb_tx`

## Requirements
- R1: After reset, usb_oe, usb_dp, usb_dm and busy are 0 and dev_addr is 0.
- R2: A request seen at a clock edge while idle sets busy=1 from that edge. For one clock the lines hold J (usb_dp=0, usb_dm=1) with usb_oe=0. At the next edge usb_oe rises together with the first bit.
- R3: Every bit lasts exactly CLKS_PER_BIT clocks. The first byte sent is the sync byte 0x80, sent LSB first: seven 0 bits, then a 1.
- R4: NRZI coding: a 0 bit toggles the line between J (dp=0, dm=1) and K (dp=1, dm=0), and a 1 bit keeps the line as it is. The lines never both read 1.
- R5: After six 1 bits in a row, one extra toggling bit is sent and the run count restarts. Any toggle also restarts the count.
- R6: A data packet sends send_len source bytes after the sync byte. For each byte, src_ready is high for exactly one clock, in the cycle the byte is taken. The block takes a byte only while src_valid is high.
- R7: After the last bit the block drives SE0 (dp=0, dm=0) for 2 bit times, then J for 1 bit time. It then sets usb_oe=0, usb_dp=0, usb_dm=0 and busy=0.
- R8: If src_valid is low when a byte is due, the packet is cut short. SE0 starts at that bit boundary, and the normal end sequence of R7 follows.
- R9: While busy, send_req and hs_req are ignored. They neither change the packet in flight nor start a packet after it.
- R10: A hs_req sends the sync byte plus hs_pid. During this packet src_ready stays 0.
- R11: dev_addr takes new_addr, if new_addr_vld is high, at the release edge of a data packet that completed. Handshake packets and aborted packets leave dev_addr unchanged.
- R12: The first sync bit is on the bus two clock edges after a request is presented. This is well inside the 60-clock reply window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, CLKS_PER_BIT per USB bit |
| rst_n | input | 1 | Active-low synchronous reset |
| send_req | input | 1 | Start a data packet (taken when idle) |
| send_len | input | LEN_W | Number of source bytes after sync |
| hs_req | input | 1 | Start a handshake packet (send_req has priority) |
| hs_pid | input | 8 | PID byte for the handshake packet |
| src_valid | input | 1 | Byte source has a byte ready |
| src_data | input | 8 | Byte from the source |
| src_ready | output | 1 | Byte taken in this cycle |
| new_addr_vld | input | 1 | A new device address is pending |
| new_addr | input | ADDR_W | Pending device address |
| dev_addr | output | ADDR_W | Device address in force |
| usb_dp | output | 1 | D+ drive value |
| usb_dm | output | 1 | D- drive value |
| usb_oe | output | 1 | Bus drive enable |
| busy | output | 1 | Packet in progress |

## Verification
Each request is presented just before a clock edge. One clock later the bench checks the J state with the enable still low. One clock after that it checks the enable high with the first K bit. After that the bench samples the lines in the middle of each 8-clock bit and decodes NRZI and stuffing back into bytes. Once it sees the first SE0 sample, 3.5 clocks into that bit, it checks the lines 12 clocks later (still SE0), 13 and 20 clocks later (J with the enable high), and 21 clocks later (released). That last sample is also where the device address is checked. All sampling falls on falling edges, so that no check sits on a transition.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
   typedef enum logic [2:0] {
      TX_IDLE,
      TX_PREP,
      TX_DATA,
      TX_SE0,
      TX_EOPJ
   } tx_state_t;

   localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/usbtx_bit_timer.sv
module usbtx_bit_timer #(
   parameter int CLKS_PER_BIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = $clog2(CLKS_PER_BIT);
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

   logic [CW-1:0] cnt;

   if (CLKS_PER_BIT < 4) begin : g_bad_rate
      $error("CLKS_PER_BIT must be at least 4");
   end

   if ((CLKS_PER_BIT & (CLKS_PER_BIT - 1)) == 0) begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n || clr) cnt <= '0;
         else               cnt <= cnt + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n || clr)  cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                cnt <= cnt + 1'b1;
      end
   end

   assign tick = (cnt == LAST) && !clr;

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/usbtx_nrzi_stuff.sv
module usbtx_nrzi_stuff #(
   parameter int STUFF_RUN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic step,
   input  logic bit_in,
   output logic stuff_due,
   output logic line_k
);
   localparam int OW = $clog2(STUFF_RUN + 1);

   logic [OW-1:0] ones;

   if (STUFF_RUN < 1) begin : g_bad_run
      $error("STUFF_RUN must be positive");
   end

   assign stuff_due = (ones == OW'(STUFF_RUN));

   always_ff @(posedge clk) begin
      if (!rst_n || init) begin
         line_k <= 1'b0;
         ones   <= '0;
      end else if (step) begin
         if (stuff_due || !bit_in) begin
            line_k <= ~line_k;
            ones   <= '0;
         end else begin
            ones <= ones + 1'b1;
         end
      end
   end

   // R5
   run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= OW'(STUFF_RUN));
   // R5
   stuff_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && stuff_due && !init) |=> (line_k != $past(line_k)));
endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
   import usbtx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 8,
   parameter int LEN_W        = 8,
   parameter int STUFF_RUN    = 6,
   parameter int ADDR_W       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_req,
   input  logic [LEN_W-1:0]  send_len,
   input  logic              hs_req,
   input  logic [7:0]        hs_pid,
   input  logic              src_valid,
   input  logic [7:0]        src_data,
   output logic              src_ready,
   input  logic              new_addr_vld,
   input  logic [ADDR_W-1:0] new_addr,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              usb_dp,
   output logic              usb_dm,
   output logic              usb_oe,
   output logic              busy
);
   localparam int BW = $clog2(8 + 1);

   if (LEN_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("LEN_W and ADDR_W must be positive");
   end

   tx_state_t         st;
   logic [7:0]        shreg;
   logic [BW-1:0]     bits_left;
   logic [LEN_W-1:0]  bytes_left;
   logic              hs_mode;
   logic [7:0]        pid_q;
   logic              aborted;
   logic              eop_half;

   logic tick, tmr_clr, start, bnd, stuff_due, line_k;
   logic byte_done, need, cur_valid, take, go_eop, enc_step, emit_bit;
   logic [7:0] cur_byte;

   assign start    = (st == TX_IDLE) && (send_req || hs_req);
   assign tmr_clr  = (st == TX_IDLE) || (st == TX_PREP);
   assign bnd      = (st == TX_PREP) || ((st == TX_DATA) && tick);
   assign byte_done = (bits_left == '0);
   assign cur_byte = hs_mode ? pid_q : src_data;
   assign cur_valid = hs_mode || src_valid;
   assign need     = bnd && !stuff_due && byte_done;
   assign take     = need && (bytes_left != '0) && cur_valid;
   assign go_eop   = need && !take;
   assign enc_step = bnd && !go_eop;
   assign emit_bit = byte_done ? cur_byte[0] : shreg[0];
   assign src_ready = take && !hs_mode;

   usbtx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .tick  (tick)
   );

   usbtx_nrzi_stuff #(.STUFF_RUN(STUFF_RUN)) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (start),
      .step      (enc_step),
      .bit_in    (emit_bit),
      .stuff_due (stuff_due),
      .line_k    (line_k)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= TX_IDLE;
         shreg      <= '0;
         bits_left  <= '0;
         bytes_left <= '0;
         hs_mode    <= 1'b0;
         pid_q      <= '0;
         aborted    <= 1'b0;
         eop_half   <= 1'b0;
         dev_addr   <= '0;
      end else begin
         unique case (st)
            TX_IDLE: if (start) begin
               st         <= TX_PREP;
               shreg      <= SYNC_BYTE;
               bits_left  <= BW'(8);
               bytes_left <= send_req ? send_len : LEN_W'(1);
               hs_mode    <= !send_req;
               pid_q      <= hs_pid;
               aborted    <= 1'b0;
            end
            TX_PREP, TX_DATA: if (bnd) begin
               if (go_eop) begin
                  st       <= TX_SE0;
                  aborted  <= (bytes_left != '0);
                  eop_half <= 1'b0;
               end else begin
                  st <= TX_DATA;
                  if (!stuff_due) begin
                     if (byte_done) begin
                        shreg      <= cur_byte >> 1;
                        bits_left  <= BW'(7);
                        bytes_left <= bytes_left - 1'b1;
                     end else begin
                        shreg     <= shreg >> 1;
                        bits_left <= bits_left - 1'b1;
                     end
                  end
               end
            end
            TX_SE0: if (tick) begin
               if (eop_half) st <= TX_EOPJ;
               eop_half <= 1'b1;
            end
            TX_EOPJ: if (tick) begin
               st <= TX_IDLE;
               if (!hs_mode && !aborted && new_addr_vld) dev_addr <= new_addr;
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      usb_dp = 1'b0;
      usb_dm = 1'b0;
      unique case (st)
         TX_PREP, TX_EOPJ: usb_dm = 1'b1;
         TX_DATA: begin
            usb_dp = line_k;
            usb_dm = ~line_k;
         end
         default: ;
      endcase
   end

   assign usb_oe = (st == TX_DATA) || (st == TX_SE0) || (st == TX_EOPJ);
   assign busy   = (st != TX_IDLE);

   // R4
   no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(usb_dp && usb_dm));
   // R2
   oe_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(usb_oe) |-> ($past(usb_dm && !usb_dp) && busy));
   // R7
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(usb_oe) |-> (!usb_dp && !usb_dm && !busy && $past(usb_dm && !usb_dp)));
   // R6
   src_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> (src_valid && usb_oe));
   // R10
   hs_no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_mode |-> !src_ready);
endmodule

// File: tb/lsusb_tx_test.sv
`timescale 1ns/1ps
module lsusb_tx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic send_req = 1'b0, hs_req = 1'b0, new_addr_vld = 1'b0;
   logic [7:0] send_len = '0, hs_pid = '0;
   logic [6:0] new_addr = '0;
   logic src_valid, src_ready, usb_dp, usb_dm, usb_oe, busy;
   logic [7:0] src_data;
   logic [6:0] dev_addr;

   logic [7:0] mem [16];
   int src_idx = 0;
   int src_avail = 0;
   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   assign src_valid = (src_idx < src_avail);
   assign src_data  = mem[src_idx[3:0]];
   always @(posedge clk) if (src_ready) src_idx <= src_idx + 1;

   lsusb_tx uut (
      .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_len(send_len),
      .hs_req(hs_req), .hs_pid(hs_pid), .src_valid(src_valid), .src_data(src_data),
      .src_ready(src_ready), .new_addr_vld(new_addr_vld), .new_addr(new_addr),
      .dev_addr(dev_addr), .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs one packet and checks framing, bytes, stuffing, timing and address.
   task automatic run_pkt(input bit hs, input int len, input int avail,
                          input logic [7:0] pid, input bit poke,
                          input int exp_stuff, input logic [6:0] exp_addr);
      logic [7:0] got [20];
      logic [7:0] acc = '0;
      bit prev_k = 1'b0, se0 = 1'b0, bit_v, aborting;
      int ones = 0, nb = 0, ng = 0, stuffs = 0, viol = 0, nexp;
      logic [7:0] expb;
      aborting = !hs && (avail < len);
      nexp = hs ? 2 : 1 + (aborting ? avail : len);
      src_idx = 0;
      src_avail = avail;
      send_len = 8'(len);
      hs_pid = pid;
      send_req = !hs;
      hs_req = hs;
      @(negedge clk);
      // R2: J on the lines, enable still low, busy set
      chk(busy && !usb_oe && usb_dm && !usb_dp, "R2",
          {busy, usb_oe, usb_dp, usb_dm}, 4'b1001);
      if (poke) begin
         send_req = 1'b1;
         hs_req = 1'b1;
         send_len = 8'd5;
      end else begin
         send_req = 1'b0;
         hs_req = 1'b0;
      end
      @(negedge clk);
      // R12: first sync bit (K) on the bus with enable high
      chk(usb_oe && usb_dp && !usb_dm, "R12", {usb_oe, usb_dp, usb_dm}, 3'b110);
      send_req = 1'b0;
      hs_req = 1'b0;
      repeat (3) @(negedge clk);
      for (int s = 0; s < 200 && !se0; s++) begin
         if (s > 0) repeat (8) @(negedge clk);
         if (!usb_dp && !usb_dm) se0 = 1'b1;
         else begin
            bit_v = (usb_dp == prev_k);
            prev_k = usb_dp;
            if (ones == 6) begin
               if (bit_v) viol++;
               stuffs++;
               ones = 0;
            end else begin
               ones = bit_v ? ones + 1 : 0;
               acc = {bit_v, acc[7:1]};
               nb++;
               if (nb == 8) begin
                  if (ng < 20) got[ng] = acc;
                  ng++;
                  nb = 0;
               end
            end
         end
      end
      // R3 / R6 / R8: whole bytes, right count
      chk(ng == nexp && nb == 0, aborting ? "R8" : "R6", ng, nexp);
      for (int i = 0; i < nexp && i < ng; i++) begin
         expb = (i == 0) ? 8'h80 : (hs ? pid : mem[i-1]);
         // R3 sync byte, R4 NRZI data, R10 PID
         chk(got[i] == expb, (i == 0) ? "R3" : (hs ? "R10" : "R4"), got[i], expb);
      end
      // R5: stuffed bits present and toggling
      chk(viol == 0 && stuffs == exp_stuff, "R5", stuffs, exp_stuff);
      // R6 / R10: bytes consumed from the source
      chk(src_idx == (hs ? 0 : nexp - 1), hs ? "R10" : "R6", src_idx, hs ? 0 : nexp - 1);
      repeat (12) @(negedge clk);
      chk(usb_oe && !usb_dp && !usb_dm, "R7", {usb_oe, usb_dp, usb_dm}, 3'b100);
      @(negedge clk);
      chk(usb_oe && !usb_dp && usb_dm, "R7", {usb_oe, usb_dp, usb_dm}, 3'b101);
      repeat (7) @(negedge clk);
      chk(usb_oe && !usb_dp && usb_dm && busy, "R7",
          {busy, usb_oe, usb_dp, usb_dm}, 4'b1101);
      @(negedge clk);
      chk(!usb_oe && !usb_dp && !usb_dm && !busy, "R7",
          {busy, usb_oe, usb_dp, usb_dm}, 4'b0000);
      // R11: address in force after release
      chk(dev_addr == exp_addr, "R11", dev_addr, exp_addr);
      if (poke) begin
         repeat (20) @(negedge clk);
         // R9: the held requests did not start another packet
         chk(!busy && !usb_oe, "R9", {busy, usb_oe}, 2'b00);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      // R1
      chk(!usb_oe && !usb_dp && !usb_dm && !busy && dev_addr == 0, "R1",
          {busy, usb_oe, usb_dp, usb_dm, 1'b0, dev_addr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!usb_oe && !busy && !src_ready, "R1", {busy, usb_oe, src_ready}, 0);
   endtask

   task automatic t_plain;
      mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h01;
      run_pkt(1'b0, 3, 3, 8'h00, 1'b0, 0, 7'h00);
   endtask

   task automatic t_stuff;
      mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'h7E;
      run_pkt(1'b0, 3, 3, 8'h00, 1'b0, 3, 7'h00);
   endtask

   task automatic t_handshake;
      new_addr = 7'h2A;
      new_addr_vld = 1'b1;
      run_pkt(1'b1, 0, 0, 8'hD2, 1'b0, 0, 7'h00);
   endtask

   task automatic t_addr;
      mem[0] = 8'h12; mem[1] = 8'h34;
      run_pkt(1'b0, 2, 2, 8'h00, 1'b0, 0, 7'h2A);
   endtask

   task automatic t_underflow;
      new_addr = 7'h15;
      mem[0] = 8'h55; mem[1] = 8'hAA;
      run_pkt(1'b0, 4, 2, 8'h00, 1'b0, 0, 7'h2A);
   endtask

   task automatic t_ignore;
      new_addr_vld = 1'b0;
      mem[0] = 8'h0F; mem[1] = 8'hF0;
      run_pkt(1'b0, 2, 8, 8'h00, 1'b1, 0, 7'h2A);
   endtask

   task automatic t_empty;
      run_pkt(1'b0, 0, 4, 8'h00, 1'b0, 0, 7'h2A);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      t_reset();
      t_plain();
      t_stuff();
      t_handshake();
      t_addr();
      t_underflow();
      t_ignore();
      t_empty();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule